// File: doc/BRIEF.md
# Leading-One Position Encoder

This block reports where the highest set bit of a parameterised input vector sits. It returns that position as a binary index, together with a flag that says whether any bit was set at all. It has no clock and no storage. The index follows the input through logic alone, so the block can be placed inside any timing path that needs a normalisation shift amount or a priority winner.

The input first passes through a parallel prefix-OR network. The network runs from the top bit downward and builds a thermometer code: every position at or below the leading one reads 1, and every position above it reads 0. The network uses doubling shifts, so it needs only ceil(log2 WIDTH) OR levels. A second stage finds the single edge of that thermometer. It forms each index bit as a balanced OR over the edge positions whose binary number has that bit set. No output bit waits on a long priority chain.

An all-zero input and an input with only bit 0 set both produce index 0. The flag tells them apart.

Top module: `lop_encoder`

## Requirements
- R1: Both outputs are pure combinational functions of `vec_i`. A new input value appears at the outputs without any clock edge.
- R2: When `vec_i` is nonzero, `idx_o` equals the position of its highest set bit, counted from bit 0 at the LSB. For example, the 9-bit input 000110101 gives 5.
- R3: `idx_o` is $clog2(WIDTH) bits wide. That is 3 bits for WIDTH=8 and 5 bits for WIDTH=32.
- R4: `any_o` is 1 exactly when at least one bit of `vec_i` is 1.
- R5: When `vec_i` is all zeros, `idx_o` is 0 and `any_o` is 0.
- R6: When only bit 0 of `vec_i` is set, `idx_o` is 0 and `any_o` is 1.
- R7: When bit WIDTH-1 is set, `idx_o` equals WIDTH-1 whatever the lower bits hold.
- R8: Bits below the leading one have no effect: changing them leaves `idx_o` and `any_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vec_i | input | WIDTH | Vector to search |
| idx_o | output | $clog2(WIDTH) | Position of the highest set bit, 0 when the vector is empty |
| any_o | output | 1 | High when any input bit is set |

## Verification
The embedded assertions re-check several properties on every input change. The prefix-OR result must have the thermometer shape. At most one edge position may be active. When the flag is high, the reported bit must be set and every bit above it must be clear. When the flag is low, the index must be zero. Two things can only be shown by the bench scenarios. The first is that the index is numerically correct, including the all-zero and lone-LSB cases. The second is that lower bits do not disturb the result. The bench shows this with an exhaustive sweep at WIDTH=8, random and masked sweeps at WIDTH=32, and the stated 9-bit example.

// File: rtl/lop_pkg.sv
package lop_pkg;

    // Index width for a given vector width; never below one bit.
    function automatic int unsigned lop_idx_width(input int unsigned width);
        return (width < 2) ? 1 : $clog2(width);
    endfunction

    // Number of doubling stages the prefix network needs.
    function automatic int unsigned lop_stage_count(input int unsigned width);
        return (width < 2) ? 1 : $clog2(width);
    endfunction

endpackage

// File: rtl/lop_prefix_or.sv
module lop_prefix_or
    import lop_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic [WIDTH-1:0] therm_o
);
    localparam int unsigned STAGES = lop_stage_count(WIDTH);

    // level[k] holds, at bit i, the OR of vec_i[i +: 2**k] (clipped at the top)
    logic [WIDTH-1:0] level_d [0:STAGES];

    assign level_d[0] = vec_i;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        localparam int unsigned SHIFT = 1 << k;
        assign level_d[k+1] = level_d[k] | (level_d[k] >> SHIFT);
    end

    assign therm_o = level_d[STAGES];

endmodule

// File: rtl/lop_therm_decode.sv
module lop_therm_decode
    import lop_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0]                    therm_i,
    output logic [lop_idx_width(WIDTH)-1:0]     idx_o,
    output logic                                any_o
);
    localparam int unsigned IDX_W = lop_idx_width(WIDTH);

    logic [WIDTH-1:0] rise_d;
    logic [WIDTH-1:0] sel_d [IDX_W];

    // Edge of the thermometer: set where this bit is 1 and the one above is 0.
    assign rise_d[WIDTH-1] = therm_i[WIDTH-1];
    for (genvar i = 0; i < WIDTH - 1; i++) begin : g_rise
        assign rise_d[i] = therm_i[i] & ~therm_i[i+1];
    end

    // Each index bit ORs the edge positions whose number carries that bit.
    for (genvar b = 0; b < IDX_W; b++) begin : g_bit
        for (genvar i = 0; i < WIDTH; i++) begin : g_pos
            if (((i >> b) & 1) == 1) begin : g_take
                assign sel_d[b][i] = rise_d[i];
            end else begin : g_skip
                assign sel_d[b][i] = 1'b0;
            end
        end
        assign idx_o[b] = |sel_d[b];
    end

    assign any_o = therm_i[0];

    always_comb begin
        for (int i = 0; i < WIDTH - 1; i++) begin
            AST_THERM_SHAPE: assert (!(therm_i[i+1] && !therm_i[i])); // R2
        end
        AST_SINGLE_EDGE: assert ($onehot0(rise_d)); // R2
    end

endmodule

// File: rtl/lop_encoder.sv
module lop_encoder
    import lop_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0]                vec_i,
    output logic [lop_idx_width(WIDTH)-1:0] idx_o,
    output logic                            any_o
);
    localparam int unsigned IDX_W = lop_idx_width(WIDTH);

    logic [WIDTH-1:0] therm_d;
    logic [IDX_W-1:0] idx_d;
    logic             any_d;

    lop_prefix_or #(.WIDTH(WIDTH)) u_prefix (
        .vec_i   (vec_i),
        .therm_o (therm_d)
    );

    lop_therm_decode #(.WIDTH(WIDTH)) u_decode (
        .therm_i (therm_d),
        .idx_o   (idx_d),
        .any_o   (any_d)
    );

    assign idx_o = idx_d;
    assign any_o = any_d;

    always_comb begin
        if (any_d) begin
            AST_LEAD_BIT_SET: assert (vec_i[idx_d] == 1'b1); // R2
            AST_ABOVE_CLEAR: assert (((vec_i >> idx_d) >> 1) == '0); // R8
        end else begin
            AST_EMPTY_IDX_ZERO: assert (idx_d == '0); // R5
            AST_EMPTY_INPUT: assert (vec_i == '0); // R4
        end
    end

endmodule

// File: tb/tb_lop_encoder.sv
`timescale 1ns/1ps
module tb_lop_encoder;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    logic [7:0]  v8  = '0;
    logic [2:0]  i8;
    logic        a8;
    logic [31:0] v32 = '0;
    logic [4:0]  i32;
    logic        a32;
    logic [8:0]  v9  = '0;
    logic [3:0]  i9;
    logic        a9;

    lop_encoder #(.WIDTH(8))  dut   (.vec_i(v8),  .idx_o(i8),  .any_o(a8));
    lop_encoder #(.WIDTH(32)) dut32 (.vec_i(v32), .idx_o(i32), .any_o(a32));
    lop_encoder #(.WIDTH(9))  dut9  (.vec_i(v9),  .idx_o(i9),  .any_o(a9));

    function automatic int ref_idx(input logic [31:0] v, input int w);
        for (int i = w - 1; i >= 0; i--) if (v[i]) return i;
        return 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R3 widths
        chk("R3 width8", $bits(i8), 3);
        chk("R3 width32", $bits(i32), 5);
        // R5 reset/empty state
        #2;
        chk("R5 idx empty", i8, 0);
        chk("R5 any empty", a8, 0);
        // R2 stated 9-bit example
        settle(); v9 = 9'b000110101; #2;
        chk("R2 example", i9, 5);
        chk("R4 example any", a9, 1);
        // Exhaustive sweep, WIDTH=8; sampled 2ns after the change, before any edge (R1)
        for (int n = 0; n < 256; n++) begin
            settle();
            v8 = n[7:0];
            #2;
            if (n == 0) begin
                chk("R5 idx", i8, 0);
                chk("R5 any", a8, 0);
            end else if (n == 1) begin
                chk("R6 idx", i8, 0);
                chk("R6 any", a8, 1);
            end else if (n[7]) begin
                chk("R7 idx", i8, 7);
                chk("R4 any", a8, 1);
            end else begin
                chk("R1 R2 idx", i8, ref_idx({24'd0, n[7:0]}, 8));
                chk("R4 any", a8, 1);
            end
        end
        // Random WIDTH=32, single-bit and sparse patterns
        for (int n = 0; n < 1500; n++) begin
            logic [31:0] r;
            r = $urandom;
            if (n % 3 == 1) r = r >> ($urandom % 32);
            if (n % 3 == 2) r = 32'd1 << ($urandom % 32);
            settle();
            v32 = r;
            #2;
            chk("R2 idx32", i32, ref_idx(r, 32));
            chk("R4 any32", a32, (r != 0) ? 1 : 0);
        end
        settle(); v32 = 32'h8000_0000; #2;
        chk("R7 top32", i32, 31);
        settle(); v32 = 32'h0000_0001; #2;
        chk("R6 lsb32 idx", i32, 0);
        chk("R6 lsb32 any", a32, 1);
        settle(); v32 = 32'h0; #2;
        chk("R5 zero32 idx", i32, 0);
        chk("R5 zero32 any", a32, 0);
        // R8: fix leading bit, scramble lower bits
        for (int t = 0; t < 32; t++) begin
            for (int k = 0; k < 6; k++) begin
                logic [31:0] low;
                logic [31:0] msk;
                low = $urandom;
                msk = (t == 0) ? 32'd0 : ((32'd1 << t) - 32'd1);
                settle();
                v32 = (32'd1 << t) | (low & msk);
                #2;
                chk("R8 idx", i32, t);
                chk("R8 any", a32, 1);
            end
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule